// File: doc/BRIEF.md
# Card Presence, Fault and Stop-Mode Supervisor

This block sits between a smart card socket's detect switches, the analog fault detectors and the host. It merges two card-detect inputs into one presence signal. One input is active high and the other is active low. A card counts as inserted only after a quiet debounce interval. A card counts as removed on the first edge that shows it gone.

The block drives an active-low status/interrupt line to the host. Outside a card session that line reports only whether a card is present. Inside a session it also drops on any fault, and an emergency-deactivate request goes to the power sequencer.

When the host parks the activate request and both supply-select pins high while the sequencer is idle, the block enters a low-power stop state. In that state the status line simply mirrors presence. On leaving the stop state, the status line stays low through a power-up delay and then a fresh debounce. The block also decodes the card supply selection from the two select pins.

Top module: `card_pres_supervisor`

## Requirements
- R1: Presence is true when `det_pos_i` is high or `det_neg_ni` is low; both pins pass through a synchroniser of `SYNC_STAGES` flops.
- R2: Outside stop, after presence becomes true, `status_no` goes high only once presence has held unchanged for `DEB_TICKS` prescaled ticks of `TICK_DIV` clocks each; it drops within a few cycles of presence going false.
- R3: Any presence change during the debounce interval restarts the interval, so a short dropout cannot shorten the wait.
- R4: With `seq_busy_i` high, loss of presence sets `emerg_deact_o` and drives `status_no` low on the first synchronised edge, with no debounce.
- R5: With `seq_busy_i` low, `emerg_deact_o` is low and the fault flags have no effect on `status_no`.
- R6: With `seq_busy_i` high, any of the overcurrent, overtemperature or supply-low flags sets `emerg_deact_o` and drives `status_no` low; both stay so until `seq_busy_i` falls.
- R7: Stop is entered (`stop_o` high) only when `act_req_ni`, `sel_low_i` and `sel_hi_i` are all high and `seq_busy_i` is low; a busy sequencer defers entry.
- R8: While `stop_o` is high, `status_no` follows the synchronised presence directly.
- R9: When any of the three mode pins goes low in stop, `stop_o` falls and `status_no` is held low for `PWRUP_TICKS` ticks, then for a full debounce interval, before normal indication resumes.
- R10: `vsel_o` is 2'b10 (1.8 V) when `sel_low_i` is high, regardless of `sel_hi_i`; otherwise 2'b01 (5 V) when `sel_hi_i` is high and 2'b00 (3 V) when it is low. The code 2'b11 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_pos_i | input | 1 | Card detect, active high, asynchronous |
| det_neg_ni | input | 1 | Card detect, active low, asynchronous |
| flt_overcur_i | input | 1 | Card supply overcurrent flag |
| flt_overtemp_i | input | 1 | Overtemperature flag |
| flt_supply_i | input | 1 | Host supply low flag |
| act_req_ni | input | 1 | Session activate request from host, active low |
| sel_low_i | input | 1 | 1.8 V select, overrides `sel_hi_i` |
| sel_hi_i | input | 1 | 5 V (high) or 3 V (low) select |
| seq_busy_i | input | 1 | Power sequencer active (session or deactivation running) |
| status_no | output | 1 | Status/interrupt to host, active low |
| emerg_deact_o | output | 1 | Emergency deactivation request |
| stop_o | output | 1 | Low-power stop state |
| vsel_o | output | 2 | Card supply code: 00 3 V, 01 5 V, 10 1.8 V |

## Verification
The assertions assume that the fault flags, the mode pins and `seq_busy_i` are synchronous to `clk_i`. They also assume that the sequencer never turns busy while the block is in stop, since activation needs `act_req_ni` low, which ends stop first. The stimulus changes these inputs only just after a rising edge. It raises `seq_busy_i` only together with a low activate request or outside stop. Only the two detect pins are treated as asynchronous.

// File: rtl/csup_pkg.sv
package csup_pkg;
  typedef enum logic [1:0] {
    M_RUN      = 2'b00,
    M_STOP     = 2'b01,
    M_WAKE_PWR = 2'b10,
    M_WAKE_DEB = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    VS_3V0 = 2'b00,
    VS_5V0 = 2'b01,
    VS_1V8 = 2'b10
  } vsel_e;
endpackage

// File: rtl/csup_sync.sv
module csup_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sh_q[i] <= RST_VAL;
        else if (i == 0) sh_q[i] <= d_i;
        else             sh_q[i] <= sh_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/csup_timer.sv
module csup_timer #(
  parameter int TICK_DIV = 4,
  parameter int TICKS    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TICKS - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (cnt_q == CNT_LAST) begin
          cnt_q  <= '0;
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;

  // R3: prescaler and tick count stay inside their windows
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_q <= PRE_LAST) && (cnt_q <= CNT_LAST));
  a_r3_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !run_q);
endmodule

// File: rtl/csup_debounce.sv
module csup_debounce #(
  parameter int TICK_DIV  = 4,
  parameter int DEB_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic present_i,
  input  logic clr_i,
  output logic ok_o
);
  logic prev_q, ok_q, chg, done;

  assign chg = present_i ^ prev_q;

  csup_timer #(.TICK_DIV(TICK_DIV), .TICKS(DEB_TICKS)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(chg | clr_i),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      prev_q <= present_i;
      // confirm only after an undisturbed interval; drop at once on absence
      ok_q   <= present_i & ~clr_i & ~chg & (ok_q | done);
    end
  end

  assign ok_o = ok_q;

  // R2: a confirmed card was present on the previous cycle
  a_r2_ok_needs_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> $past(present_i));
  // R3: a change always leaves the card unconfirmed
  a_r3_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_i != prev_q) |=> !ok_o);
endmodule

// File: rtl/csup_mode.sv
module csup_mode
  import csup_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int PWRUP_TICKS = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  act_req_ni,
  input  logic  sel_low_i,
  input  logic  sel_hi_i,
  input  logic  seq_busy_i,
  input  logic  deb_ok_i,
  input  logic  pres_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;
  logic  park_req, wake_start, pwr_done;

  assign park_req   = act_req_ni & sel_low_i & sel_hi_i;
  assign wake_start = (mode_q == M_STOP) && !park_req;

  csup_timer #(.TICK_DIV(TICK_DIV), .TICKS(PWRUP_TICKS)) u_pwr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wake_start),
    .done_o (pwr_done)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_RUN:      if (park_req && !seq_busy_i) mode_d = M_STOP;
      M_STOP:     if (!park_req) mode_d = M_WAKE_PWR;
      M_WAKE_PWR: if (pwr_done && !wake_start) mode_d = M_WAKE_DEB;
      M_WAKE_DEB: if (deb_ok_i || !pres_i) mode_d = M_RUN;
      default:    mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= M_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R7: stop is reached only from an idle sequencer with all three pins high
  a_r7_stop_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o == M_STOP) |-> $past(park_req && !seq_busy_i));
  // R9: leaving stop always goes through the power-up wait
  a_r9_wake_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_STOP) |=> (mode_o == M_STOP) || (mode_o == M_WAKE_PWR));
endmodule

// File: rtl/card_pres_supervisor.sv
module card_pres_supervisor
  import csup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 4,
  parameter int DEB_TICKS   = 5,
  parameter int PWRUP_TICKS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       det_pos_i,
  input  logic       det_neg_ni,
  input  logic       flt_overcur_i,
  input  logic       flt_overtemp_i,
  input  logic       flt_supply_i,
  input  logic       act_req_ni,
  input  logic       sel_low_i,
  input  logic       sel_hi_i,
  input  logic       seq_busy_i,
  output logic       status_no,
  output logic       emerg_deact_o,
  output logic       stop_o,
  output logic [1:0] vsel_o
);
  logic  pos_s, neg_s, pres_s, deb_ok, deb_clr, flt_any, flt_q;
  mode_e mode;

  csup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(det_pos_i), .q_o(pos_s));
  csup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_neg (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(det_neg_ni), .q_o(neg_s));

  assign pres_s  = pos_s | ~neg_s;
  assign deb_clr = (mode == M_STOP) || (mode == M_WAKE_PWR);

  csup_debounce #(.TICK_DIV(TICK_DIV), .DEB_TICKS(DEB_TICKS)) u_deb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .present_i(pres_s),
    .clr_i    (deb_clr),
    .ok_o     (deb_ok)
  );

  csup_mode #(.TICK_DIV(TICK_DIV), .PWRUP_TICKS(PWRUP_TICKS)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_req_ni(act_req_ni),
    .sel_low_i (sel_low_i),
    .sel_hi_i  (sel_hi_i),
    .seq_busy_i(seq_busy_i),
    .deb_ok_i  (deb_ok),
    .pres_i    (pres_s),
    .mode_o    (mode)
  );

  assign flt_any = flt_overcur_i | flt_overtemp_i | flt_supply_i;

  // session fault latch: removal or any fault, held until the sequencer idles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flt_q <= 1'b0;
    else         flt_q <= seq_busy_i & (flt_q | flt_any | ~pres_s);
  end

  always_comb begin
    unique case (mode)
      M_RUN:   status_no = deb_ok & ~flt_q;
      M_STOP:  status_no = pres_s;
      default: status_no = 1'b0;
    endcase
  end

  assign emerg_deact_o = flt_q;
  assign stop_o        = (mode == M_STOP);

  always_comb begin
    if (sel_low_i)     vsel_o = VS_1V8;
    else if (sel_hi_i) vsel_o = VS_5V0;
    else               vsel_o = VS_3V0;
  end

  // R4: removal in session requests deactivation on the next cycle
  a_r4_removal_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy_i && !pres_s) |=> emerg_deact_o);
  // R5: no deactivation request outside a session
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_busy_i |=> !emerg_deact_o);
  // R6: fault in session pulls the status line low
  a_r6_fault_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy_i && flt_any && !stop_o) |=> !status_no);
  // R9: status is asserted as stop is left
  a_r9_wake_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_o) |-> !status_no);
  // R10: reserved supply code never produced
  a_r10_vsel_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsel_o != 2'b11);
endmodule

// File: tb/card_pres_supervisor_tb.sv
module card_pres_supervisor_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic det_pos = 1'b0, det_neg_n = 1'b1;
  logic f_oc = 1'b0, f_ot = 1'b0, f_sup = 1'b0;
  logic act_n = 1'b1, s_low = 1'b0, s_hi = 1'b0, busy = 1'b0;
  logic status_n, emerg, stop;
  logic [1:0] vsel;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  typedef struct {
    int         at;
    int         sig;   // 0 status, 1 emerg, 2 stop, 3 vsel
    logic [1:0] val;
    string      req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  card_pres_supervisor #(.SYNC_STAGES(2), .TICK_DIV(4), .DEB_TICKS(5), .PWRUP_TICKS(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .det_pos_i(det_pos), .det_neg_ni(det_neg_n),
    .flt_overcur_i(f_oc), .flt_overtemp_i(f_ot), .flt_supply_i(f_sup),
    .act_req_ni(act_n), .sel_low_i(s_low), .sel_hi_i(s_hi), .seq_busy_i(busy),
    .status_no(status_n), .emerg_deact_o(emerg), .stop_o(stop), .vsel_o(vsel));

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item due this cycle, mid-period
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        logic [1:0] act;
        case (q[i].sig)
          0: act = {1'b0, status_n};
          1: act = {1'b0, emerg};
          2: act = {1'b0, stop};
          default: act = vsel;
        endcase
        checks++;
        if (act !== q[i].val) begin
          failures++;
          $display("FAIL %s sig=%0d actual=%0h expected=%0h cyc=%0d",
                   q[i].req, q[i].sig, act, q[i].val, cyc);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_in(int d, int sig, logic [1:0] val, string req);
    exp_t e;
    e.at = cyc + d; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // reset state
    expect_in(1, 0, 2'd0, "R2 reset status");
    expect_in(1, 1, 2'd0, "R5 reset emerg");
    expect_in(1, 2, 2'd0, "R7 reset stop");
    expect_in(1, 3, 2'b00, "R10 3V");
    tick(3);
    // R10 supply decode
    s_hi = 1'b1; expect_in(1, 3, 2'b01, "R10 5V"); tick(3);
    s_hi = 1'b0; s_low = 1'b1; expect_in(1, 3, 2'b10, "R10 1V8"); tick(3);
    act_n = 1'b0; tick(1); s_hi = 1'b1;
    expect_in(1, 3, 2'b10, "R10 1V8 priority");
    expect_in(3, 2, 2'd0, "R7 no stop with request low");
    tick(4);
    s_low = 1'b0; s_hi = 1'b0; act_n = 1'b1; tick(2);
    // R1/R2 insertion via active-high pin
    det_pos = 1'b1;
    expect_in(18, 0, 2'd0, "R2 debounce pending");
    expect_in(28, 0, 2'd1, "R1 R2 present after debounce");
    tick(30);
    det_pos = 1'b0;
    expect_in(5, 0, 2'd0, "R2 removal idle");
    tick(8);
    // R1/R3 insertion via active-low pin with a dropout
    det_neg_n = 1'b0; tick(10);
    det_neg_n = 1'b1; tick(3);
    det_neg_n = 1'b0;
    expect_in(12, 0, 2'd0, "R3 restart after dropout");
    expect_in(18, 0, 2'd0, "R3 still waiting");
    expect_in(28, 0, 2'd1, "R1 R3 present");
    tick(30);
    // R5 faults ignored outside a session
    f_oc = 1'b1; f_ot = 1'b1;
    expect_in(3, 0, 2'd1, "R5 fault ignored status");
    expect_in(3, 1, 2'd0, "R5 fault ignored emerg");
    tick(5);
    f_oc = 1'b0; f_ot = 1'b0;
    // R6 session faults
    act_n = 1'b0; busy = 1'b1;
    expect_in(2, 0, 2'd1, "R6 session healthy");
    expect_in(2, 1, 2'd0, "R6 session no request");
    tick(4);
    f_ot = 1'b1;
    expect_in(2, 1, 2'd1, "R6 overtemp request");
    expect_in(2, 0, 2'd0, "R6 overtemp status");
    tick(2); f_ot = 1'b0;
    expect_in(3, 1, 2'd1, "R6 held until idle");
    tick(4);
    busy = 1'b0; act_n = 1'b1;
    expect_in(2, 1, 2'd0, "R6 released");
    expect_in(2, 0, 2'd1, "R5 status back to presence");
    tick(4);
    act_n = 1'b0; busy = 1'b1; f_sup = 1'b1;
    expect_in(2, 1, 2'd1, "R6 supply low request");
    tick(3); f_sup = 1'b0; busy = 1'b0; act_n = 1'b1; tick(3);
    f_oc = 1'b1; act_n = 1'b0; busy = 1'b1;
    expect_in(2, 0, 2'd0, "R6 overcurrent status");
    tick(3); f_oc = 1'b0; busy = 1'b0; act_n = 1'b1; tick(3);
    // R4 removal in session
    act_n = 1'b0; busy = 1'b1; tick(3);
    det_neg_n = 1'b1;
    expect_in(3, 1, 2'd1, "R4 removal request");
    expect_in(3, 0, 2'd0, "R4 removal status");
    tick(5);
    busy = 1'b0; act_n = 1'b1; tick(2);
    det_neg_n = 1'b0; tick(30);
    // R7 stop deferred while busy
    busy = 1'b1; s_low = 1'b1; s_hi = 1'b1;
    expect_in(3, 2, 2'd0, "R7 busy defers stop");
    tick(4);
    busy = 1'b0;
    expect_in(2, 2, 2'd1, "R7 stop entered");
    tick(4);
    // R8 status mirrors presence in stop
    det_neg_n = 1'b1;
    expect_in(3, 0, 2'd0, "R8 stop absent");
    tick(4);
    det_neg_n = 1'b0;
    expect_in(3, 0, 2'd1, "R8 stop present");
    tick(4);
    // R9 wake-up
    s_hi = 1'b0;
    expect_in(2, 2, 2'd0, "R9 stop left");
    expect_in(2, 0, 2'd0, "R9 held at wake");
    expect_in(30, 0, 2'd0, "R9 held through debounce");
    expect_in(42, 0, 2'd1, "R9 normal indication");
    tick(45);
    s_low = 1'b0;
    tick(4);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard pending=%0d expected=0", q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule